// File: doc/BRIEF.md
# Priority-Encoded Multi-Operation Register

This block is a parameterised storage register with four separate active-high operation requests: clear to zeros, set to ones, parallel load, and shift left with a serial fill bit. If more than one request is high, a fixed priority decides which one takes effect. The winning request becomes a 3-bit operation code. That code steers a one-of-eight selector in front of every flip-flop. The register changes only on a rising clock edge. With no request high it keeps its contents.

The four requests are resolved in this order, strongest first: clear, set, load, shift. Operation codes: 000 hold, 001 load, 010 shift left, 011 clear, 100 set. Codes 101, 110 and 111 keep the present value. The encoder is built so that it cannot produce these three codes. A synchronous active-high reset zeroes the register and takes precedence over every request. The output comes straight from the register.

Top module: `prio_multiop_reg`

## Requirements
- R1: When `rst` is high at a rising edge, `q_o` is all zeros after that edge, whatever the requests are.
- R2: With `rst` low and `clr_req` high, `q_o` becomes all zeros at the edge, whatever `set_req`, `load_req` and `shl_req` are.
- R3: With `clr_req` low and `set_req` high, `q_o` becomes all ones at the edge, whatever `load_req` and `shl_req` are.
- R4: With `clr_req` and `set_req` low and `load_req` high, `q_o` takes `din` at the edge, whatever `shl_req` is.
- R5: When `shl_req` is the only request high, bit i of `q_o` takes the old bit i-1 at the edge, and bit 0 takes `shl_fill`.
- R6: With all four requests low, `q_o` keeps its value at the edge, whatever `din` and `shl_fill` are.
- R7: Requests act only at a rising edge: `q_o` does not change between edges when requests change.
- R8: The operation codes are 000 hold, 001 load, 010 shift, 011 clear and 100 set. The encoder never produces 101, 110 or 111, and the selector treats those codes as hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero |
| clr_req | input | 1 | Clear request (highest priority) |
| set_req | input | 1 | Set-to-ones request |
| load_req | input | 1 | Parallel load request |
| shl_req | input | 1 | Shift-left request (lowest priority) |
| shl_fill | input | 1 | Bit shifted into position 0 |
| din | input | WIDTH | Parallel load data |
| q_o | output | WIDTH | Registered contents |

## Verification
The hardest behaviour to reach is the fallback of codes 101 to 111 to hold. The encoder cannot emit them, so no sequence at the ports can reach them. The encoder instead carries a property stating that its code never exceeds 100. The bench drives all sixteen request combinations from several preloaded values. Each combination is tried with both fill values and with data that differs from the stored value. This way a wrong priority or a stray code shows up as a changed output. A mid-cycle probe of the output catches any request that acts between edges.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_HOLD = 3'b000;
  localparam logic [OP_W-1:0] OP_LOAD = 3'b001;
  localparam logic [OP_W-1:0] OP_SHL  = 3'b010;
  localparam logic [OP_W-1:0] OP_CLR  = 3'b011;
  localparam logic [OP_W-1:0] OP_SET  = 3'b100;
endpackage

// File: rtl/pmr_op_encoder.sv
module pmr_op_encoder
  import pmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_req,
  input  logic            set_req,
  input  logic            load_req,
  input  logic            shl_req,
  output logic [OP_W-1:0] op
);
  // Strict priority: clear, set, load, shift
  always_comb begin
    op[2] = ~clr_req & set_req;
    op[1] = clr_req | (~clr_req & ~set_req & ~load_req & shl_req);
    op[0] = clr_req | (~clr_req & ~set_req & load_req);
  end

  // R8: the three spare codes are never produced
  a_r8_no_spare_code: assert property (@(posedge clk) disable iff (rst)
    op <= OP_SET);
endmodule

// File: rtl/pmr_bit_slice.sv
module pmr_bit_slice
  import pmr_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            cur,
  input  logic            load_bit,
  input  logic            lower,
  output logic            nxt
);
  always_comb begin
    case (op)
      OP_LOAD: nxt = load_bit;
      OP_SHL:  nxt = lower;
      OP_CLR:  nxt = 1'b0;
      OP_SET:  nxt = 1'b1;
      default: nxt = cur; // 000 and the spare codes keep the bit
    endcase
  end
endmodule

// File: rtl/prio_multiop_reg.sv
module prio_multiop_reg
  import pmr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_req,
  input  logic             set_req,
  input  logic             load_req,
  input  logic             shl_req,
  input  logic             shl_fill,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [OP_W-1:0]  op;
  logic [WIDTH-1:0] q_next;
  logic [WIDTH:0]   lower_vec;

  pmr_op_encoder u_enc (
    .clk(clk), .rst(rst), .clr_req(clr_req), .set_req(set_req),
    .load_req(load_req), .shl_req(shl_req), .op(op)
  );

  assign lower_vec = {q_o, shl_fill};

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    pmr_bit_slice u_bit (
      .op(op), .cur(q_o[i]), .load_bit(din[i]),
      .lower(lower_vec[i]), .nxt(q_next[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= q_next;
  end

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> q_o == '0);
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> q_o == '0);
  a_r3_set_ones: assert property (@(posedge clk) disable iff (rst)
    (!clr_req && set_req) |=> q_o == ALL_ONES);
  a_r4_load_data: assert property (@(posedge clk) disable iff (rst)
    (!clr_req && !set_req && load_req) |=> q_o == $past(din));
  a_r5_shift_left: assert property (@(posedge clk) disable iff (rst)
    (!clr_req && !set_req && !load_req && shl_req)
      |=> q_o == $past(lower_vec[WIDTH-1:0]));
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!clr_req && !set_req && !load_req && !shl_req) |=> $stable(q_o));
endmodule

// File: tb/tb_prio_multiop_reg.sv
module tb_prio_multiop_reg;
  localparam int W = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, clr_req, set_req, load_req, shl_req, shl_fill;
  logic [W-1:0] din, q_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_multiop_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .clr_req(clr_req), .set_req(set_req),
    .load_req(load_req), .shl_req(shl_req), .shl_fill(shl_fill),
    .din(din), .q_o(q_o)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (q_o !== exp) begin
      errors++;
      $display("FAIL %s: q_o=%b expected=%b", req, q_o, exp);
    end
  endtask

  task automatic drive(input logic c, s, l, h, f, input logic [W-1:0] d);
    clr_req = c; set_req = s; load_req = l; shl_req = h;
    shl_fill = f; din = d;
  endtask

  // one edge: drive at negedge, outcome visible at following negedge
  task automatic step(input logic c, s, l, h, f, input logic [W-1:0] d);
    drive(c, s, l, h, f, d);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] model(input logic c, s, l, h, f,
                                         input logic [W-1:0] d, cur);
    if (c)      return '0;
    else if (s) return '1;
    else if (l) return d;
    else if (h) return {cur[W-2:0], f};
    else        return cur;
  endfunction

  function automatic string tag(input logic c, s, l, h);
    if (c)      return "R2 R8 clear";
    else if (s) return "R3 R8 set";
    else if (l) return "R4 R8 load";
    else if (h) return "R5 R8 shift";
    else        return "R6 R8 hold";
  endfunction

  initial begin
    logic [W-1:0] starts [4];
    logic [W-1:0] exp;
    starts[0] = 4'b1001; starts[1] = 4'b0110;
    starts[2] = 4'b0000; starts[3] = 4'b1111;

    rst = 1'b1;
    drive(1, 1, 1, 1, 1, 4'b1010);
    @(negedge clk); @(negedge clk);
    check("R1 reset state", '0);

    // sweep all request combinations from several start values
    rst = 1'b0;
    for (int si = 0; si < 4; si++) begin
      for (int combo = 0; combo < 16; combo++) begin
        for (int f = 0; f < 2; f++) begin
          logic c, s, l, h;
          logic [W-1:0] d;
          c = combo[3]; s = combo[2]; l = combo[1]; h = combo[0];
          d = ~starts[si] ^ W'(combo);
          step(0, 0, 1, 0, 0, starts[si]);
          exp = model(c, s, l, h, f[0], d, starts[si]);
          step(c, s, l, h, f[0], d);
          check(tag(c, s, l, h), exp);
        end
      end
    end

    // four successive shifts with zero fill
    step(0, 0, 1, 0, 0, 4'b1001);
    step(0, 0, 0, 1, 0, 4'b0000); check("R5 shift 1", 4'b0010);
    step(0, 0, 0, 1, 0, 4'b1111); check("R5 shift 2", 4'b0100);
    step(0, 0, 0, 1, 0, 4'b0000); check("R5 shift 3", 4'b1000);
    step(0, 0, 0, 1, 0, 4'b0000); check("R5 shift 4", 4'b0000);
    // ones fill
    step(0, 0, 0, 1, 1, 4'b0000); check("R5 fill one", 4'b0001);

    // requests change mid-cycle: output must stay until the edge
    step(0, 0, 1, 0, 0, 4'b0101);
    drive(1, 0, 0, 0, 0, 4'b0000);
    #1 check("R7 clear waits for edge", 4'b0101);
    drive(0, 1, 0, 0, 0, 4'b0000);
    #1 check("R7 set waits for edge", 4'b0101);
    drive(0, 0, 1, 0, 0, 4'b1010);
    #1 check("R7 load waits for edge", 4'b0101);
    @(negedge clk);
    check("R7 load at edge", 4'b1010);

    // reset overrides a set request
    rst = 1'b1;
    step(0, 1, 0, 0, 0, 4'b1111);
    check("R1 reset over set", '0);
    rst = 1'b0;

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule